// File: doc/BRIEF.md
# SMI Feature Handshake and Dispatch Unit

This unit settles, once per reset, which system-management-interrupt features the host and the guest firmware agree to use, and then turns writes to the power-management command port into SMI pulses for the CPUs. The host's supported set is fixed by a parameter. Firmware writes the set it wants into a request register. It then writes the commit register, and the unit checks the request against the supported set and against the dependency rules among three feature bits. A request that passes is copied into the agreed set, and from then on that set is frozen until the next reset.

The command port also carries two reserved byte codes that turn ACPI mode on and off. Every other byte code becomes an SMI, provided the command-port enable bit of the SMI enable register is set. The SMI goes to every CPU when broadcast is in the agreed set, and otherwise only to the CPU that wrote the command. A lock bit in a power-control register, once set, freezes both itself and that enable bit.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, the request, commit flag, agreed set, SMI enable and power-control registers all read 0. `acpi_mode` is 0 and `smi_pulse` is all zero.
- R2: Register address 0 reads the host supported mask (default 0x7). `host_cfg_err` is 1 exactly when the mask has the hot-unplug bit (bit 2) set and the hotplug bit (bit 1) clear.
- R3: A commit whose request has any bit outside the host mask is rejected. The commit flag (address 2, bit 0) and the agreed set (address 3) stay 0.
- R4: A commit whose request sets hotplug (bit 1) or hot-unplug (bit 2) while broadcast (bit 0) is clear is rejected.
- R5: A commit whose request sets hot-unplug without hotplug is rejected.
- R6: A commit of a valid request copies the request (address 1) into the agreed set and sets the commit flag to 1.
- R7: Once the commit flag is 1, further commits are ignored and the agreed set stays unchanged, even after the request register has been rewritten.
- R8: A command byte of 0xE1 sets `acpi_mode` and a command byte of 0xE0 clears it. Neither raises an SMI.
- R9: Any other command byte raises an SMI, one cycle after the write, only when bit 0 of the SMI enable register (address 4) is set. The pulse lasts exactly one cycle.
- R10: The SMI pulse has every bit set when broadcast (bit 0) is in the agreed set. Otherwise only bit `apm_cpu` is set.
- R11: After bit 4 of the power-control register (address 5) is written to 1, that bit can no longer be cleared, and bit 0 of the SMI enable register keeps its value. The other enable bits stay writable.
- R12: A reset issued after a successful commit clears the request, the commit flag and the agreed set, and a new commit is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 host, 1 request, 2 commit, 3 agreed, 4 SMI enable, 5 power control |
| reg_wdata | input | FEAT_W | Write data |
| reg_rdata | output | FEAT_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| apm_wr | input | 1 | Command port write strobe |
| apm_cmd | input | 8 | Command byte |
| apm_cpu | input | CPU_W | Index of the CPU making the command write |
| acpi_mode | output | 1 | ACPI mode state |
| smi_pulse | output | NCPU | One-cycle SMI pulse, one bit per CPU |
| host_cfg_err | output | 1 | Host mask offers hot-unplug without hotplug |

## Verification
The hardest state to reach is the frozen handshake. Reaching it takes rejected commits first, then a successful one, then a rewritten request and a second commit. Only then can the bench show that the agreed set and the broadcast fan-out ignore the new request. The stimulus walks the request through every rejection rule before the accepting commit. It then checks the command-port fan-out both before and after broadcast becomes part of the agreed set. Finally it resets mid-run and negotiates again.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int BCAST_BIT   = 0;
  localparam int HOTPLUG_BIT = 1;
  localparam int UNPLUG_BIT  = 2;
  localparam int APMC_EN_BIT = 0;
  localparam int LOCK_BIT    = 4;

  typedef enum logic [2:0] {
    A_HOST  = 3'd0,
    A_REQ   = 3'd1,
    A_OK    = 3'd2,
    A_NEG   = 3'd3,
    A_SMIEN = 3'd4,
    A_PMCTL = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/smi_feat_neg.sv
module smi_feat_neg
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W = 64,
  parameter logic [FEAT_W-1:0] HOST_FEAT = 'h7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic [FEAT_W-1:0] req_data,
  input  logic              ok_wr,
  output logic [FEAT_W-1:0] req_q,
  output logic              ok_q,
  output logic [FEAT_W-1:0] neg_q,
  output logic              cfg_err
);
  localparam logic HOST_BAD = HOST_FEAT[UNPLUG_BIT] & ~HOST_FEAT[HOTPLUG_BIT];

  logic outside, hp_no_bcast, unplug_alone, accept;

  always_comb begin
    outside      = |(req_q & ~HOST_FEAT);
    hp_no_bcast  = (req_q[HOTPLUG_BIT] | req_q[UNPLUG_BIT]) & ~req_q[BCAST_BIT];
    unplug_alone = req_q[UNPLUG_BIT] & ~req_q[HOTPLUG_BIT];
    accept       = ok_wr & ~ok_q & ~outside & ~hp_no_bcast & ~unplug_alone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      ok_q  <= 1'b0;
      neg_q <= '0;
    end else begin
      if (req_wr) req_q <= req_data;
      if (accept) begin
        neg_q <= req_q;
        ok_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) cfg_err <= HOST_BAD;
endmodule

// File: rtl/smi_pm_regs.sv
module smi_pm_regs
  import smi_neg_pkg::*;
#(
  parameter int SMIEN_W = 32,
  parameter int PMCTL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smien_wr,
  input  logic [SMIEN_W-1:0] smien_data,
  input  logic               pmctl_wr,
  input  logic [PMCTL_W-1:0] pmctl_data,
  output logic [SMIEN_W-1:0] smien_q,
  output logic [PMCTL_W-1:0] pmctl_q,
  output logic               lock
);
  localparam logic [PMCTL_W-1:0] LOCK_MASK = PMCTL_W'(1) << LOCK_BIT;

  assign lock = pmctl_q[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      smien_q <= '0;
      pmctl_q <= '0;
    end else begin
      if (pmctl_wr) pmctl_q <= lock ? (pmctl_data | LOCK_MASK) : pmctl_data;
      if (smien_wr) begin
        smien_q <= smien_data;
        if (lock) smien_q[APMC_EN_BIT] <= smien_q[APMC_EN_BIT];
      end
    end
  end
endmodule

// File: rtl/smi_apm_dispatch.sv
module smi_apm_dispatch #(
  parameter int NCPU = 4,
  parameter int CPU_W = 2,
  parameter logic [7:0] ACPI_ON  = 8'hE1,
  parameter logic [7:0] ACPI_OFF = 8'hE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             apm_wr,
  input  logic [7:0]       apm_cmd,
  input  logic [CPU_W-1:0] apm_cpu,
  input  logic             apmc_en,
  input  logic             bcast,
  output logic             acpi_mode,
  output logic [NCPU-1:0]  smi_pulse
);
  logic is_acpi, fire;

  always_comb begin
    is_acpi = (apm_cmd == ACPI_ON) || (apm_cmd == ACPI_OFF);
    fire    = apm_wr & ~is_acpi & apmc_en;
  end

  always_ff @(posedge clk) begin
    if (rst) acpi_mode <= 1'b0;
    else if (apm_wr && apm_cmd == ACPI_ON) acpi_mode <= 1'b1;
    else if (apm_wr && apm_cmd == ACPI_OFF) acpi_mode <= 1'b0;
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) smi_pulse[i] <= 1'b0;
      else smi_pulse[i] <= fire & (bcast | (apm_cpu == CPU_W'(i)));
    end
  end
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
  import smi_neg_pkg::*;
#(
  parameter int FEAT_W  = 64,
  parameter logic [FEAT_W-1:0] HOST_FEAT = 'h7,
  parameter int NCPU    = 4,
  parameter int CPU_W   = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter int SMIEN_W = 32,
  parameter int PMCTL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [FEAT_W-1:0] reg_wdata,
  output logic [FEAT_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              apm_wr,
  input  logic [7:0]        apm_cmd,
  input  logic [CPU_W-1:0]  apm_cpu,
  output logic              acpi_mode,
  output logic [NCPU-1:0]   smi_pulse,
  output logic              host_cfg_err
);
  logic [FEAT_W-1:0]  req_q, neg_q;
  logic               ok_q, lock;
  logic [SMIEN_W-1:0] smien_q;
  logic [PMCTL_W-1:0] pmctl_q;

  smi_feat_neg #(.FEAT_W(FEAT_W), .HOST_FEAT(HOST_FEAT)) u_neg (
    .clk(clk), .rst(rst),
    .req_wr(reg_wr && reg_addr == A_REQ), .req_data(reg_wdata),
    .ok_wr(reg_wr && reg_addr == A_OK),
    .req_q(req_q), .ok_q(ok_q), .neg_q(neg_q), .cfg_err(host_cfg_err)
  );

  smi_pm_regs #(.SMIEN_W(SMIEN_W), .PMCTL_W(PMCTL_W)) u_pm (
    .clk(clk), .rst(rst),
    .smien_wr(reg_wr && reg_addr == A_SMIEN), .smien_data(reg_wdata[SMIEN_W-1:0]),
    .pmctl_wr(reg_wr && reg_addr == A_PMCTL), .pmctl_data(reg_wdata[PMCTL_W-1:0]),
    .smien_q(smien_q), .pmctl_q(pmctl_q), .lock(lock)
  );

  smi_apm_dispatch #(.NCPU(NCPU), .CPU_W(CPU_W)) u_apm (
    .clk(clk), .rst(rst),
    .apm_wr(apm_wr), .apm_cmd(apm_cmd), .apm_cpu(apm_cpu),
    .apmc_en(smien_q[APMC_EN_BIT]), .bcast(neg_q[BCAST_BIT]),
    .acpi_mode(acpi_mode), .smi_pulse(smi_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          A_HOST:  reg_rdata <= HOST_FEAT;
          A_REQ:   reg_rdata <= req_q;
          A_OK:    reg_rdata <= FEAT_W'(ok_q);
          A_NEG:   reg_rdata <= neg_q;
          A_SMIEN: reg_rdata <= FEAT_W'(smien_q);
          A_PMCTL: reg_rdata <= FEAT_W'(pmctl_q);
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smi_negotiator_chk.sv
module smi_negotiator_chk #(
  parameter int FEAT_W  = 64,
  parameter logic [FEAT_W-1:0] HOST_FEAT = 'h7,
  parameter int NCPU    = 4,
  parameter int SMIEN_W = 32,
  parameter int PMCTL_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               apm_wr,
  input logic [7:0]         apm_cmd,
  input logic [NCPU-1:0]    smi_pulse,
  input logic [FEAT_W-1:0]  req_q,
  input logic [FEAT_W-1:0]  neg_q,
  input logic               ok_q,
  input logic [SMIEN_W-1:0] smien_q,
  input logic               lock
);
  assert_agreed_subset_R3: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> ((neg_q & ~HOST_FEAT) == '0));

  assert_commit_copies_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_q) |-> neg_q == $past(req_q));

  assert_agreed_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    ok_q |=> (ok_q && $stable(neg_q)));

  assert_acpi_cmd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (apm_wr && (apm_cmd == 8'hE0 || apm_cmd == 8'hE1)) |=> smi_pulse == '0);

  assert_smi_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    (smi_pulse != '0) |-> ($past(apm_wr) && $past(smien_q[0])));

  assert_single_target_R10: assert property (@(posedge clk) disable iff (rst)
    (smi_pulse != '0 && !neg_q[0]) |-> $countones(smi_pulse) == 1);

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    lock |=> (lock && $stable(smien_q[0])));
endmodule

bind smi_negotiator smi_negotiator_chk #(
  .FEAT_W(FEAT_W), .HOST_FEAT(HOST_FEAT), .NCPU(NCPU),
  .SMIEN_W(SMIEN_W), .PMCTL_W(PMCTL_W)
) u_chk (
  .clk(clk), .rst(rst), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
  .smi_pulse(smi_pulse), .req_q(req_q), .neg_q(neg_q), .ok_q(ok_q),
  .smien_q(smien_q), .lock(lock)
);

// File: tb/test_smi_negotiator.sv
module test_smi_negotiator;
  localparam int CLK_PERIOD = 10;
  localparam int FEAT_W = 64;
  localparam int NCPU = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [FEAT_W-1:0] reg_wdata = '0;
  logic [FEAT_W-1:0] reg_rdata;
  logic reg_rvalid;
  logic apm_wr = 1'b0;
  logic [7:0] apm_cmd = '0;
  logic [1:0] apm_cpu = '0;
  logic acpi_mode;
  logic [NCPU-1:0] smi_pulse;
  logic host_cfg_err;

  logic [FEAT_W-1:0] b_rdata;
  logic b_rvalid, b_acpi, b_cfg_err;
  logic [NCPU-1:0] b_pulse;

  int checks = 0;
  int errors = 0;
  logic [FEAT_W-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_negotiator #(.FEAT_W(FEAT_W), .NCPU(NCPU)) i_smi_negotiator (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .apm_wr(apm_wr), .apm_cmd(apm_cmd), .apm_cpu(apm_cpu),
    .acpi_mode(acpi_mode), .smi_pulse(smi_pulse), .host_cfg_err(host_cfg_err)
  );

  smi_negotiator #(.FEAT_W(FEAT_W), .HOST_FEAT(64'h5), .NCPU(NCPU)) i_bad_cfg (
    .clk(clk), .rst(rst), .reg_wr(1'b0), .reg_rd(1'b0), .reg_addr(3'd0),
    .reg_wdata('0), .reg_rdata(b_rdata), .reg_rvalid(b_rvalid),
    .apm_wr(1'b0), .apm_cmd(8'd0), .apm_cpu(2'd0),
    .acpi_mode(b_acpi), .smi_pulse(b_pulse), .host_cfg_err(b_cfg_err)
  );

  task automatic check(input string tag, input logic [FEAT_W-1:0] act, input logic [FEAT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (reg_rvalid) begin
      if (exp_q.size() == 0) check("unexpected read", 1, 0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [FEAT_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [FEAT_W-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic apm(input logic [7:0] cmd, input logic [1:0] cpu,
                     input logic [NCPU-1:0] exp_pulse, input logic exp_acpi, input string tag);
    @(negedge clk);
    apm_wr = 1'b1; apm_cmd = cmd; apm_cpu = cpu;
    @(negedge clk);
    apm_wr = 1'b0;
    check({tag, " pulse"}, FEAT_W'(smi_pulse), FEAT_W'(exp_pulse));
    check({tag, " acpi"}, FEAT_W'(acpi_mode), FEAT_W'(exp_acpi));
    @(negedge clk);
    check({tag, " pulse one cycle"}, FEAT_W'(smi_pulse), '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 acpi", FEAT_W'(acpi_mode), '0);
    check("R1 pulse", FEAT_W'(smi_pulse), '0);
    rd(3'd1, 0, "R1 request");
    rd(3'd2, 0, "R1 ok");
    rd(3'd3, 0, "R1 agreed");
    rd(3'd4, 0, "R1 smien");
    rd(3'd5, 0, "R1 pmctl");
    // R2 host mask and config error
    rd(3'd0, 64'h7, "R2 host mask");
    check("R2 good cfg", FEAT_W'(host_cfg_err), '0);
    check("R2 bad cfg", FEAT_W'(b_cfg_err), 1);
    // R3 outside host mask
    wr(3'd1, 64'h21); wr(3'd2, 1);
    rd(3'd2, 0, "R3 ok");
    rd(3'd3, 0, "R3 agreed");
    // R4 hotplug without broadcast
    wr(3'd1, 64'h2); wr(3'd2, 1);
    rd(3'd2, 0, "R4 ok hotplug");
    wr(3'd1, 64'h6); wr(3'd2, 1);
    rd(3'd2, 0, "R4 ok both");
    // R5 unplug without hotplug
    wr(3'd1, 64'h5); wr(3'd2, 1);
    rd(3'd2, 0, "R5 ok");
    rd(3'd3, 0, "R5 agreed");
    // R9 disabled then enabled, R10 single target
    apm(8'h55, 2'd2, 4'b0000, 1'b0, "R9 disabled");
    wr(3'd4, 1);
    apm(8'h55, 2'd2, 4'b0100, 1'b0, "R10 single");
    // R8 ACPI commands
    apm(8'hE1, 2'd0, 4'b0000, 1'b1, "R8 on");
    apm(8'hE0, 2'd0, 4'b0000, 1'b0, "R8 off");
    // R6 valid commit
    wr(3'd1, 64'h3); wr(3'd2, 1);
    rd(3'd2, 1, "R6 ok");
    rd(3'd3, 64'h3, "R6 agreed");
    // R7 frozen
    wr(3'd1, 64'h1); wr(3'd2, 1);
    rd(3'd1, 64'h1, "R7 request");
    rd(3'd3, 64'h3, "R7 agreed");
    // R10 broadcast
    apm(8'h40, 2'd1, 4'b1111, 1'b0, "R10 broadcast");
    // R11 lock
    wr(3'd5, 64'h10);
    wr(3'd4, 0);
    rd(3'd4, 64'h1, "R11 enable frozen");
    wr(3'd4, 64'h6);
    rd(3'd4, 64'h7, "R11 other bits");
    wr(3'd5, 0);
    rd(3'd5, 64'h10, "R11 lock sticky");
    apm(8'h41, 2'd3, 4'b1111, 1'b0, "R11 still fires");
    // R12 reset clears, renegotiate
    do_reset();
    rd(3'd1, 0, "R12 request");
    rd(3'd2, 0, "R12 ok");
    rd(3'd3, 0, "R12 agreed");
    wr(3'd1, 64'h1); wr(3'd2, 1);
    rd(3'd3, 64'h1, "R12 renegotiated");
    repeat (3) @(negedge clk);
    check("read queue drained", FEAT_W'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule